// File: doc/BRIEF.md
# Watchdog Heartbeat Period Extender

A hardware watchdog can only count a short interval before it escalates, first to an interrupt, then to a non-maskable interrupt, then to a chip reset. This block lets software ask for a much longer heartbeat by counting many short watchdog periods. It services the watchdog's first-stage interrupt: each time it fires, the block pokes the watchdog, and while armed it also counts down one period. When the countdown is used up, the block stops poking and masks the interrupt. The watchdog then runs on through its remaining two stages, which are therefore budgeted as the last two periods of the heartbeat.

Software writes a heartbeat in seconds together with the largest base period the watchdog supports. The block searches downward from that maximum, one candidate per clock, for the largest period that divides the heartbeat exactly. From the quotient it computes the reload value for the countdown. A user ping pokes the watchdog, reloads the countdown and, when appropriate, unmasks the interrupt.

Top module: `hb_period_extender`

## Requirements
- R1: After a configuration with heartbeat H and maximum M, the reported base period is the largest integer P with 1 <= P <= M that divides H exactly; an M of 0 is treated as 1.
- R2: The reload value is H/P - 2 when H/P exceeds 2 and 0 otherwise; each ping copies it into the countdown.
- R3: While `arm` is low, every unmasked `wd_irq` produces a one-cycle `poke` one cycle later and leaves the countdown unchanged.
- R4: While `arm` is high, an unmasked `wd_irq` with a nonzero countdown produces a `poke` and lowers the countdown by one.
- R5: While `arm` is high, an unmasked `wd_irq` with a zero countdown produces no `poke` and clears `irq_en`; while `irq_en` is low, `wd_irq` produces no `poke`.
- R6: A ping produces a `poke`, reloads the countdown, and sets `irq_en` if the reload is nonzero or `arm` is low. Otherwise `irq_en` keeps its value. A ping takes priority over a `wd_irq` in the same cycle.
- R7: A configuration with heartbeat 0 is ignored: `search_done` stays high and the base period is unchanged.
- R8: The search tests one candidate per cycle, from M downward. `search_done` is low for the whole search and rises M - P + 1 cycles after the configuration cycle.
- R9: A ping that arrives during a search is held. It takes effect in the cycle after `search_done` rises and uses the new reload.
- R10: After reset, `poke` is 0, `irq_en` is 1, `search_done` is 1, `base_period` is 0, and the countdown and reload are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Load a new heartbeat and start a search |
| cfg_heartbeat | input | HB_W | Requested heartbeat in seconds |
| max_period | input | PER_W | Largest base period the watchdog supports |
| arm | input | 1 | Countdown mode enable |
| ping | input | 1 | User keep-alive strobe |
| wd_irq | input | 1 | Watchdog first-stage interrupt |
| poke | output | 1 | One-cycle watchdog restart strobe |
| irq_en | output | 1 | Watchdog interrupt enable |
| base_period | output | PER_W | Selected base period in seconds |
| search_done | output | 1 | High when no divisor search is running |

## Verification
Every output is a register, so `poke` and `irq_en` respond on the first clock edge after the interrupt or ping that causes them. The bench drives on falling edges and samples one full cycle later. A search result shows on `search_done` and `base_period` exactly M - P + 1 edges after the configuration edge. The bench counts those edges and compares the count with the value computed from the requirement. A held ping is checked one cycle after `search_done` is seen high. The countdown has no port of its own. Its value is checked by counting how many interrupts produce a poke before the first one that does not.

// File: rtl/hb_period_extender.sv
`timescale 1ns/1ps
module hb_period_extender #(
  parameter int HB_W  = 16,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [HB_W-1:0]  cfg_heartbeat,
  input  logic [PER_W-1:0] max_period,
  input  logic             arm,
  input  logic             ping,
  input  logic             wd_irq,
  output logic             poke,
  output logic             irq_en,
  output logic [PER_W-1:0] base_period,
  output logic             search_done
);
  logic [HB_W-1:0]  hb_q, reload_q, cnt_q;
  logic [PER_W-1:0] cand_q, base_q;
  logic             busy_q, pend_q, irq_en_q, poke_q;

  wire [PER_W-1:0] max_safe = (max_period == '0) ? PER_W'(1) : max_period;
  wire [HB_W-1:0]  cand_w   = (cand_q == '0) ? HB_W'(1) : HB_W'(cand_q);
  wire             hit      = (hb_q % cand_w) == '0;
  wire [HB_W-1:0]  quo      = hb_q / cand_w;
  wire             cfg_go   = cfg_valid && (cfg_heartbeat != '0);
  wire             ping_go  = !busy_q && (ping || pend_q);
  wire             irq_go   = wd_irq && irq_en_q && !ping_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hb_q <= '0; reload_q <= '0; cnt_q <= '0;
      cand_q <= PER_W'(1); base_q <= '0;
      busy_q <= 1'b0; pend_q <= 1'b0; irq_en_q <= 1'b1; poke_q <= 1'b0;
    end else begin
      poke_q <= ping_go || (irq_go && (!arm || cnt_q != '0));

      if (cfg_go) begin
        hb_q   <= cfg_heartbeat;
        cand_q <= max_safe;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (hit) begin
          base_q   <= cand_q;
          reload_q <= (quo > HB_W'(2)) ? quo - HB_W'(2) : '0;
          busy_q   <= 1'b0;
        end else begin
          cand_q <= cand_q - PER_W'(1);
        end
      end

      if (ping_go)             pend_q <= 1'b0;
      else if (ping && busy_q) pend_q <= 1'b1;

      if (ping_go) begin
        cnt_q <= reload_q;
        if (reload_q != '0 || !arm) irq_en_q <= 1'b1;
      end else if (irq_go && arm) begin
        if (cnt_q != '0) cnt_q <= cnt_q - HB_W'(1);
        else             irq_en_q <= 1'b0;
      end
    end
  end

  assign poke        = poke_q;
  assign irq_en      = irq_en_q;
  assign base_period = base_q;
  assign search_done = !busy_q;

  assert_mask_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_en) |-> $past(arm && wd_irq) && !poke);
  assert_poke_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    poke |-> $past(wd_irq || ping || pend_q));
  assert_divides_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(search_done) |-> (hb_q % HB_W'(base_period)) == '0);
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q) && !$past(ping_go)) |-> cnt_q == $past(cnt_q) - HB_W'(1));
  assert_reject_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_valid && cfg_heartbeat == '0 && !busy_q) |-> search_done && $stable(base_period));
endmodule

// File: tb/tb_hb_period_extender.sv
`timescale 1ns/1ps
module tb_hb_period_extender;
  logic clk = 0, rst_n = 0, cfg_valid = 0, arm = 0, ping = 0, wd_irq = 0;
  logic [15:0] cfg_heartbeat = 0;
  logic [2:0]  max_period = 0;
  logic poke, irq_en, search_done;
  logic [2:0] base_period;
  int checks = 0, failures = 0;

  hb_period_extender dut (.clk, .rst_n, .cfg_valid, .cfg_heartbeat, .max_period,
    .arm, .ping, .wd_irq, .poke, .irq_en, .base_period, .search_done);

  always #2.5 clk = ~clk;

  // {heartbeat, max, expected base, expected search cycles}
  localparam int VEC [8][4] = '{
    '{60,5,5,1}, '{7,5,1,5}, '{12,5,4,2}, '{9,5,3,3},
    '{30,4,3,2}, '{1,5,1,5}, '{11,3,1,3}, '{8,0,1,1}};

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin failures++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic configure(input int hb, input int mx, output int n);
    cfg_heartbeat = 16'(hb); max_period = 3'(mx); cfg_valid = 1; step(); cfg_valid = 0;
    n = 0;
    do begin step(); n++; end while (!search_done && n < 20);
  endtask

  task automatic do_ping(); ping = 1; step(); ping = 0; endtask
  task automatic do_irq(output bit p); wd_irq = 1; step(); wd_irq = 0; p = poke; endtask

  task automatic count_pokes(output int n);
    bit p; n = 0;
    for (int i = 0; i < 40; i++) begin do_irq(p); if (!p) break; n++; end
  endtask

  initial begin
    #500000;
    failures++; $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n; bit p;
    @(negedge clk); step(); rst_n = 1; step();
    // R10 reset state
    check(poke == 0, "R10 poke", poke, 0);
    check(irq_en == 1, "R10 irq_en", irq_en, 1);
    check(search_done == 1, "R10 done", search_done, 1);
    check(base_period == 0, "R10 base", base_period, 0);

    // R1 and R8 table
    for (int i = 0; i < 8; i++) begin
      configure(VEC[i][0], VEC[i][1], n);
      check(base_period == 3'(VEC[i][2]), "R1 base period", base_period, VEC[i][2]);
      check(n == VEC[i][3], "R8 search cycles", n, VEC[i][3]);
    end

    // R7 zero heartbeat ignored
    cfg_heartbeat = 0; max_period = 5; cfg_valid = 1; step(); cfg_valid = 0;
    check(search_done == 1, "R7 done stays", search_done, 1);
    check(base_period == 1, "R7 base kept", base_period, 1);

    // heartbeat 60, max 5: base 5, reload 10
    configure(60, 5, n);
    arm = 0; do_irq(p);
    check(p == 1, "R3 unarmed poke", p, 1);
    arm = 1; do_ping();
    check(poke == 1, "R6 ping poke", poke, 1);
    count_pokes(n);
    check(n == 10, "R4 R2 armed pokes before mask", n, 10);
    check(irq_en == 0, "R5 masked", irq_en, 0);
    do_irq(p);
    check(p == 0, "R5 masked irq no poke", p, 0);
    do_ping();
    check(irq_en == 1, "R6 unmask", irq_en, 1);
    // ping and irq together: ping wins, countdown reloaded
    for (int i = 0; i < 3; i++) do_irq(p);
    ping = 1; wd_irq = 1; step(); ping = 0; wd_irq = 0;
    check(poke == 1, "R6 ping priority poke", poke, 1);
    count_pokes(n);
    check(n == 10, "R6 ping priority reload", n, 10);

    // heartbeat 2: base 2, reload 0
    configure(2, 5, n);
    do_ping();
    check(irq_en == 0, "R6 zero reload keeps mask", irq_en, 0);
    arm = 0; do_ping();
    check(irq_en == 1, "R6 unarmed unmask", irq_en, 1);
    arm = 1; do_irq(p);
    check(p == 0 && irq_en == 0, "R5 zero count masks", p, 0);

    // R9 held ping during search: heartbeat 7, max 5 -> reload 5
    cfg_heartbeat = 7; max_period = 5; cfg_valid = 1; step(); cfg_valid = 0;
    ping = 1; step(); ping = 0;
    check(poke == 0, "R9 no poke while busy", poke, 0);
    n = 0;
    while (!search_done && n < 20) begin step(); n++; end
    check(poke == 0, "R9 no poke at done", poke, 0);
    step();
    check(poke == 1, "R9 held ping", poke, 1);
    check(irq_en == 1, "R9 held ping unmask", irq_en, 1);
    count_pokes(n);
    check(n == 5, "R9 R2 new reload used", n, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule